// File: doc/BRIEF.md
# Power State and Wake Gating Controller

This block holds the power state of a network controller and decides, from that state and the wake settings, three things: whether the receiver stays powered, which received packets go into the receive FIFO, and when the active-low wake pin is driven. Software programs a power state of D0, D1, D2 or D3hot, a wake-pin enable and a set of wake-event enables through a simple write strobe. A separate input reports whether bus power is present. When bus power is lost, the block is in D3cold regardless of the programmed state.

The receive path supplies one-hot packet type flags together with a valid level and an end-of-frame strobe. While the wake pin is enabled, only packets whose type is enabled as a wake event are accepted, and this holds in every power state. An accepted wake packet sets a sticky status bit on the edge that closes the frame. The packet itself stays in the FIFO. The pin remains low until software clears the status bit. Outside D0 the block grants no bus-master permission, so the only action it can start there is the wake pin. When bus power returns, the state goes back to D0 and wake-pin assertion is disabled.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, `pwr_state_o` is 0 (D0), `wake_sts_o` is 0, `pme_n_o` is 1, `rx_alive_o` and `bus_init_ok_o` are 1, wake-pin assertion is disabled and no wake event is enabled.
- R2: A write (`cfg_we_i` high while `bus_pwr_ok_i` is high and was high on the previous edge) loads the power state, wake-pin enable and event enables on that edge. `pwr_state_o` shows the programmed code afterwards: 0 for D0, 1 for D1, 2 for D2, 3 for D3hot.
- R3: While `bus_pwr_ok_i` is low, `pwr_state_o` is 4 (D3cold) in the same cycle, and configuration writes are ignored.
- R4: On the first edge with `bus_pwr_ok_i` high after it was low, the state returns to D0 and wake-pin assertion is disabled: `pme_n_o` goes high and packet filtering stops. A write on that edge is ignored.
- R5: `rx_alive_o` is 1 in D0, D1 and D2. In D3hot it equals the wake-pin enable. In D3cold it is 1 only when the wake pin is enabled and at least one event bit is set.
- R6: `pkt_accept_o` is 1 only when `pkt_vld_i` and `rx_alive_o` are both 1. When the wake pin is enabled, `pkt_type_i & evt_en` must also be nonzero. Bit i of `pkt_type_i` is packet type i, and bit i of the event enables enables type i.
- R7: `bus_init_ok_o` is 1 only in D0.
- R8: An accepted packet with its end-of-frame strobe, while the wake pin is enabled and its type matches an enabled event, makes `wake_sts_o` 1 from the next edge on. `pme_n_o` is low whenever `wake_sts_o` is 1 and the wake pin is enabled.
- R9: With no matching enabled event, or with the wake pin disabled, an end-of-frame leaves `wake_sts_o` at 0.
- R10: `wake_sts_o` stays 1 until an edge with `wake_clr_i` high clears it. A set on the same edge takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_pwr_ok_i | input | 1 | Bus power present; low means D3cold |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_pstate_i | input | 2 | Programmed state: 0 D0, 1 D1, 2 D2, 3 D3hot |
| cfg_pin_en_i | input | 1 | Wake-pin assertion enable |
| cfg_evt_en_i | input | N_EVT | Wake-event enable per packet type |
| wake_clr_i | input | 1 | Clears sticky wake status |
| pkt_vld_i | input | 1 | Packet type flags valid |
| pkt_eof_i | input | 1 | End-of-frame strobe of current packet |
| pkt_type_i | input | N_EVT | One-hot packet type flags |
| pwr_state_o | output | 3 | Effective state, 4 = D3cold |
| rx_alive_o | output | 1 | Receiver powered |
| pkt_accept_o | output | 1 | Current packet goes to the FIFO |
| bus_init_ok_o | output | 1 | Bus-master activity permitted |
| wake_sts_o | output | 1 | Sticky wake status |
| pme_n_o | output | 1 | Wake pin, active low |

## Verification
A corrupted state or enable register shows up at the ports at once. It changes `pwr_state_o`, `bus_init_ok_o` and `rx_alive_o`, and the accept decision for the next packet, in the same cycle, because those outputs are combinational from the registers. A wrong wake latch shows one edge after the end-of-frame, on `wake_sts_o` and `pme_n_o`. A missed power-return reset shows on the edge after bus power rises, as a state other than 0 or a pin still low. The bench walks a table of state, enable and type combinations, then drives directed wake, clear and power-loss sequences.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  localparam int PW_STATE_W = 3;
  localparam int PW_PROG_W  = 2;

  typedef enum logic [PW_STATE_W-1:0] {
    PW_D0     = 3'd0,
    PW_D1     = 3'd1,
    PW_D2     = 3'd2,
    PW_D3HOT  = 3'd3,
    PW_D3COLD = 3'd4
  } pw_state_e;
endpackage

// File: rtl/pw_cfg_regs.sv
module pw_cfg_regs
  import pwr_wake_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_pwr_ok_i,
  input  logic                 cfg_we_i,
  input  logic [PW_PROG_W-1:0] cfg_pstate_i,
  input  logic                 cfg_pin_en_i,
  input  logic [N_EVT-1:0]     cfg_evt_en_i,
  output pw_state_e            state_o,
  output logic                 pin_en_o,
  output logic [N_EVT-1:0]     evt_en_o
);
  logic [PW_PROG_W-1:0] prog_q;
  logic                 pin_en_q;
  logic [N_EVT-1:0]     evt_en_q;
  logic                 bus_q;
  logic                 pwr_back;

  assign pwr_back = bus_pwr_ok_i & ~bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q   <= '0;
      pin_en_q <= 1'b0;
      evt_en_q <= '0;
      bus_q    <= 1'b1;
    end else begin
      bus_q <= bus_pwr_ok_i;
      if (pwr_back) begin
        // return from D3cold: back to D0, pin assertion off
        prog_q   <= '0;
        pin_en_q <= 1'b0;
      end else if (cfg_we_i && bus_pwr_ok_i) begin
        prog_q   <= cfg_pstate_i;
        pin_en_q <= cfg_pin_en_i;
        evt_en_q <= cfg_evt_en_i;
      end
    end
  end

  assign state_o  = bus_pwr_ok_i ? pw_state_e'({1'b0, prog_q}) : PW_D3COLD;
  assign pin_en_o = pin_en_q;
  assign evt_en_o = evt_en_q;
endmodule

// File: rtl/pw_rx_gate.sv
module pw_rx_gate
  import pwr_wake_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  pw_state_e        state_i,
  input  logic             pin_en_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  logic             pkt_vld_i,
  input  logic [N_EVT-1:0] pkt_type_i,
  output logic             rx_alive_o,
  output logic             accept_o,
  output logic             match_o,
  output logic             bus_init_o
);
  logic [N_EVT-1:0] hit;
  logic             any_evt;

  for (genvar i = 0; i < N_EVT; i++) begin : g_hit
    assign hit[i] = pkt_type_i[i] & evt_en_i[i];
  end

  assign match_o = |hit;
  assign any_evt = |evt_en_i;

  always_comb begin
    unique case (state_i)
      PW_D0, PW_D1, PW_D2: rx_alive_o = 1'b1;
      PW_D3HOT:            rx_alive_o = pin_en_i;
      PW_D3COLD:           rx_alive_o = pin_en_i & any_evt;
      default:             rx_alive_o = 1'b0;
    endcase
  end

  // wake-pin enable adds type filtering in every state
  assign accept_o   = pkt_vld_i & rx_alive_o & (~pin_en_i | match_o);
  assign bus_init_o = (state_i == PW_D0);
endmodule

// File: rtl/pw_wake_latch.sv
module pw_wake_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_o <= 1'b0;
    else if (set_i)  sts_o <= 1'b1;
    else if (clr_i)  sts_o <= 1'b0;
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_pwr_ok_i,
  input  logic                  cfg_we_i,
  input  logic [PW_PROG_W-1:0]  cfg_pstate_i,
  input  logic                  cfg_pin_en_i,
  input  logic [N_EVT-1:0]      cfg_evt_en_i,
  input  logic                  wake_clr_i,
  input  logic                  pkt_vld_i,
  input  logic                  pkt_eof_i,
  input  logic [N_EVT-1:0]      pkt_type_i,
  output logic [PW_STATE_W-1:0] pwr_state_o,
  output logic                  rx_alive_o,
  output logic                  pkt_accept_o,
  output logic                  bus_init_ok_o,
  output logic                  wake_sts_o,
  output logic                  pme_n_o
);
  pw_state_e        state;
  logic             pin_en;
  logic [N_EVT-1:0] evt_en;
  logic             match;
  logic             wake_set;

  pw_cfg_regs #(.N_EVT(N_EVT)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_pwr_ok_i (bus_pwr_ok_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_pstate_i (cfg_pstate_i),
    .cfg_pin_en_i (cfg_pin_en_i),
    .cfg_evt_en_i (cfg_evt_en_i),
    .state_o      (state),
    .pin_en_o     (pin_en),
    .evt_en_o     (evt_en)
  );

  pw_rx_gate #(.N_EVT(N_EVT)) u_gate (
    .state_i    (state),
    .pin_en_i   (pin_en),
    .evt_en_i   (evt_en),
    .pkt_vld_i  (pkt_vld_i),
    .pkt_type_i (pkt_type_i),
    .rx_alive_o (rx_alive_o),
    .accept_o   (pkt_accept_o),
    .match_o    (match),
    .bus_init_o (bus_init_ok_o)
  );

  assign wake_set = pkt_eof_i & pkt_accept_o & pin_en & match;

  pw_wake_latch u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wake_set),
    .clr_i  (wake_clr_i),
    .sts_o  (wake_sts_o)
  );

  assign pwr_state_o = state;
  assign pme_n_o     = ~(wake_sts_o & pin_en);
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
  parameter int N_EVT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_pwr_ok_i,
  input logic             wake_clr_i,
  input logic             pkt_vld_i,
  input logic             pkt_eof_i,
  input logic [N_EVT-1:0] pkt_type_i,
  input logic [2:0]       pwr_state_o,
  input logic             rx_alive_o,
  input logic             pkt_accept_o,
  input logic             bus_init_ok_o,
  input logic             wake_sts_o,
  input logic             pme_n_o
);
  assert_d3cold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_pwr_ok_i |-> pwr_state_o == 3'd4);

  assert_pwr_return_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_pwr_ok_i) |=> (pwr_state_o == 3'd0 || !bus_pwr_ok_i) && pme_n_o);

  assert_accept_alive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_accept_o |-> rx_alive_o && pkt_vld_i);

  assert_bus_init_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_init_ok_o |-> pwr_state_o == 3'd0);

  assert_wake_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_sts_o) |-> $past(pkt_eof_i && pkt_accept_o && |pkt_type_i));

  assert_pin_needs_sts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pme_n_o |-> wake_sts_o);

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_sts_o && !wake_clr_i |=> wake_sts_o);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.N_EVT(N_EVT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_pwr_ok_i  (bus_pwr_ok_i),
  .wake_clr_i    (wake_clr_i),
  .pkt_vld_i     (pkt_vld_i),
  .pkt_eof_i     (pkt_eof_i),
  .pkt_type_i    (pkt_type_i),
  .pwr_state_o   (pwr_state_o),
  .rx_alive_o    (rx_alive_o),
  .pkt_accept_o  (pkt_accept_o),
  .bus_init_ok_o (bus_init_ok_o),
  .wake_sts_o    (wake_sts_o),
  .pme_n_o       (pme_n_o)
);

// File: tb/pwr_wake_ctrl_tb.sv
`timescale 1ns/100ps
module pwr_wake_ctrl_tb;
  localparam int N_EVT = 4;
  localparam int NVEC  = 13;

  // {bus, pstate, pin, evt, type, alive, accept, businit, state}
  typedef struct packed {
    logic       bus;
    logic [1:0] ps;
    logic       pin;
    logic [3:0] evt;
    logic [3:0] typ;
    logic       alive;
    logic       acc;
    logic       bi;
    logic [2:0] st;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 1'b0, 4'b0000, 4'b0001, 1'b1, 1'b1, 1'b1, 3'd0},
    '{1'b1, 2'd1, 1'b0, 4'b0000, 4'b0010, 1'b1, 1'b1, 1'b0, 3'd1},
    '{1'b1, 2'd2, 1'b0, 4'b0000, 4'b0100, 1'b1, 1'b1, 1'b0, 3'd2},
    '{1'b1, 2'd3, 1'b0, 4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, 3'd3},
    '{1'b1, 2'd3, 1'b1, 4'b0010, 4'b0010, 1'b1, 1'b1, 1'b0, 3'd3},
    '{1'b1, 2'd3, 1'b1, 4'b0010, 4'b0001, 1'b1, 1'b0, 1'b0, 3'd3},
    '{1'b1, 2'd0, 1'b1, 4'b0100, 4'b0001, 1'b1, 1'b0, 1'b1, 3'd0},
    '{1'b1, 2'd0, 1'b1, 4'b0100, 4'b0100, 1'b1, 1'b1, 1'b1, 3'd0},
    '{1'b0, 2'd0, 1'b1, 4'b1000, 4'b1000, 1'b1, 1'b1, 1'b0, 3'd4},
    '{1'b0, 2'd1, 1'b1, 4'b0000, 4'b1000, 1'b0, 1'b0, 1'b0, 3'd4},
    '{1'b0, 2'd2, 1'b0, 4'b1111, 4'b0001, 1'b0, 1'b0, 1'b0, 3'd4},
    '{1'b1, 2'd1, 1'b1, 4'b0011, 4'b0100, 1'b1, 1'b0, 1'b0, 3'd1},
    '{1'b1, 2'd3, 1'b1, 4'b0000, 4'b0001, 1'b1, 1'b0, 1'b0, 3'd3}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bus_pwr_ok_i = 1'b1;
  logic             cfg_we_i = 1'b0;
  logic [1:0]       cfg_pstate_i = '0;
  logic             cfg_pin_en_i = 1'b0;
  logic [N_EVT-1:0] cfg_evt_en_i = '0;
  logic             wake_clr_i = 1'b0;
  logic             pkt_vld_i = 1'b0;
  logic             pkt_eof_i = 1'b0;
  logic [N_EVT-1:0] pkt_type_i = '0;
  logic [2:0]       pwr_state_o;
  logic             rx_alive_o, pkt_accept_o, bus_init_ok_o, wake_sts_o, pme_n_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwr_wake_ctrl #(.N_EVT(N_EVT)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic cfg_write(input logic [1:0] ps, input logic pin, input logic [3:0] evt);
    cfg_we_i = 1'b1; cfg_pstate_i = ps; cfg_pin_en_i = pin; cfg_evt_en_i = evt;
    tick();
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    tick();
    // R1 reset state
    pkt_vld_i = 1'b1; pkt_type_i = 4'b0001;
    #1;
    check("R1 state", pwr_state_o, 0);
    check("R1 wake_sts", wake_sts_o, 0);
    check("R1 pme_n", pme_n_o, 1);
    check("R1 alive", rx_alive_o, 1);
    check("R1 businit", bus_init_ok_o, 1);
    check("R1 accept unfiltered", pkt_accept_o, 1);
    pkt_vld_i = 1'b0;

    // table walk: R2 R3 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      bus_pwr_ok_i = 1'b1;
      tick();
      cfg_write(VECS[i].ps, VECS[i].pin, VECS[i].evt);
      bus_pwr_ok_i = VECS[i].bus;
      pkt_vld_i = 1'b1; pkt_type_i = VECS[i].typ;
      #1;
      check($sformatf("R2/R3 state vec%0d", i), pwr_state_o, VECS[i].st);
      check($sformatf("R5 alive vec%0d", i), rx_alive_o, VECS[i].alive);
      check($sformatf("R6 accept vec%0d", i), pkt_accept_o, VECS[i].acc);
      check($sformatf("R7 businit vec%0d", i), bus_init_ok_o, VECS[i].bi);
      pkt_vld_i = 1'b0;
      tick();
    end
    bus_pwr_ok_i = 1'b1;
    tick();
    tick();

    // R6 invalid packet never accepted
    cfg_write(2'd0, 1'b0, 4'b0000);
    pkt_type_i = 4'b0001; pkt_vld_i = 1'b0;
    #1 check("R6 no vld", pkt_accept_o, 0);

    // R9 pin disabled: eof gives no wake
    pkt_vld_i = 1'b1; pkt_eof_i = 1'b1;
    tick();
    pkt_eof_i = 1'b0;
    check("R9 pin off no wake", wake_sts_o, 0);

    // R9 pin enabled, type not enabled
    cfg_write(2'd3, 1'b1, 4'b0010);
    pkt_type_i = 4'b0001; pkt_eof_i = 1'b1;
    tick();
    pkt_eof_i = 1'b0;
    check("R9 mismatch no wake", wake_sts_o, 0);
    check("R9 pme_n", pme_n_o, 1);

    // R8 wake packet
    pkt_type_i = 4'b0010; pkt_eof_i = 1'b1;
    #1 check("R8 not before edge", wake_sts_o, 0);
    tick();
    pkt_eof_i = 1'b0; pkt_vld_i = 1'b0;
    check("R8 wake_sts set", wake_sts_o, 1);
    check("R8 pme_n low", pme_n_o, 0);

    // R10 sticky, then clear
    tick(); tick();
    check("R10 sticky", wake_sts_o, 1);
    wake_clr_i = 1'b1;
    tick();
    wake_clr_i = 1'b0;
    check("R10 cleared", wake_sts_o, 0);
    check("R10 pme_n high", pme_n_o, 1);

    // R10 set beats clear
    pkt_vld_i = 1'b1; pkt_type_i = 4'b0010; pkt_eof_i = 1'b1; wake_clr_i = 1'b1;
    tick();
    pkt_eof_i = 1'b0; wake_clr_i = 1'b0; pkt_vld_i = 1'b0;
    check("R10 set priority", wake_sts_o, 1);

    // R3 write ignored in D3cold; R4 return to D0, pin off
    bus_pwr_ok_i = 1'b0;
    tick();
    check("R3 d3cold", pwr_state_o, 4);
    check("R3 pme held in d3cold", pme_n_o, 0);
    cfg_write(2'd2, 1'b1, 4'b0001);
    bus_pwr_ok_i = 1'b1;
    cfg_write(2'd1, 1'b1, 4'b0001);
    check("R4 state D0", pwr_state_o, 0);
    check("R4 pme_n high", pme_n_o, 1);
    check("R4 sts kept", wake_sts_o, 1);
    pkt_vld_i = 1'b1; pkt_type_i = 4'b0001;
    #1 check("R4 filter off", pkt_accept_o, 1);
    pkt_vld_i = 1'b0;
    // R2 normal write after return works
    cfg_write(2'd2, 1'b0, 4'b0000);
    check("R2 write after return", pwr_state_o, 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule